// File: doc/BRIEF.md
# Single-Shot Translation Fault Capture Registers

This block sits beside an address-translation walker and records the first translation or protection fault it reports. On a fault strobe it latches the stream number, the fault code, the access direction, the 64-bit faulting device address and the page-table walk indices. It keeps them frozen until software writes a clear, so the first fault of a burst is the one that survives.

The same block classifies each captured fault against an engine status byte. A status whose low seven bits equal 0x20, with bit 7 ignored, marks the fault as benign. Any other status makes it real and raises a sticky interrupt. A 32-bit register port exposes the capture words. It also exposes a stream-enable bitmap, a small array of per-stream table-base words, and a translation-buffer status word.

Top module: `fault_capture_regs`

## Requirements
- R1: After reset every register reads zero and `fault_irq` is low.
- R2: A fault strobe while no fault is held sets the capture in the next cycle. Status word 0x40 then reads bit 31 = 1, bit 30 = write (1) or read (0), bits 19:16 = stream ID and bits 7:0 = fault code. Offset 0x50 reads address bits 31:0 and 0x54 reads address bits 63:32. Offset 0x44 reads the L3 index in bits 10:0, the L2 index in bits 21:11 and the table index in bits 29:28.
- R3: While a fault is held, further fault strobes change none of 0x40, 0x44, 0x50, 0x54 or `fault_irq`.
- R4: Writing a word with bit 31 = 1 to 0x40 makes the status word read zero and lowers `fault_irq` in the next cycle, and capture is armed again. Writing with bit 31 = 0 has no effect. The address and index words keep their last captured values.
- R5: A fault strobe in the same cycle as a clear write is captured, replacing the held fault.
- R6: On capture, `fault_irq` rises in the next cycle unless the engine status has bits 6:0 equal to 0x20 (bit 7 ignored). It stays high until a clear.
- R7: Offset 0xfc holds a read/write stream-enable bitmap of NSTREAM bits (4 by default) in its low bits, and its upper bits read zero.
- R8: Offsets 0x200 + 4*i, for i below NSTREAM, hold read/write 32-bit table-base words.
- R9: Offset 0x100c reads `tb_busy` live in bit 0 and the held-fault flag in bit 1. All other bits read zero.
- R10: Offsets that are not implemented read zero, and writes to them change nothing. Writes to 0x44, 0x50, 0x54 and 0x100c are also ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flt_valid | input | 1 | Fault strobe from the walker |
| flt_write | input | 1 | Faulting access was a write |
| flt_sid | input | SID_W | Stream ID of the faulting access |
| flt_code | input | CODE_W | Fault code |
| flt_addr | input | 64 | Faulting device address |
| flt_tti | input | TTI_W | Translation-table index of the walk |
| flt_l2 | input | L2_W | Level-2 walk index |
| flt_l3 | input | L3_W | Level-3 walk index |
| eng_status | input | 8 | Engine status byte used to classify the fault |
| tb_busy | input | 1 | Translation buffer busy |
| bus_sel | input | 1 | Register access select |
| bus_wr | input | 1 | Access is a write |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational on bus_addr |
| fault_irq | output | 1 | Sticky real-fault interrupt |

## Verification
The hardest case to reach is a clear write and a new fault strobe landing in the same clock while a fault is already held. That one edge must drop the old capture and take the new one, and the interrupt must follow the new classification. The bench drives both in one task on a single cycle, with a benign status and then with a real one, and reads every capture word afterwards. The benign filter is probed at status values that differ from 0x20 or 0xa0 only in bit 7, or only in a low bit.

// File: rtl/fault_capture_regs.sv
module fault_capture_regs #(
  parameter int ADDR_W  = 16,
  parameter int SID_W   = 4,
  parameter int CODE_W  = 8,
  parameter int TTI_W   = 2,
  parameter int L2_W    = 11,
  parameter int L3_W    = 11,
  parameter int NSTREAM = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flt_valid,
  input  logic              flt_write,
  input  logic [SID_W-1:0]  flt_sid,
  input  logic [CODE_W-1:0] flt_code,
  input  logic [63:0]       flt_addr,
  input  logic [TTI_W-1:0]  flt_tti,
  input  logic [L2_W-1:0]   flt_l2,
  input  logic [L3_W-1:0]   flt_l3,
  input  logic [7:0]        eng_status,
  input  logic              tb_busy,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              fault_irq
);
  localparam int SID_LSB = 16;
  localparam int L2_LSB  = L3_W;
  localparam int TTI_LSB = 28;
  localparam logic [ADDR_W-1:0] OFF_STAT = ADDR_W'(16'h0040);
  localparam logic [ADDR_W-1:0] OFF_IDX  = ADDR_W'(16'h0044);
  localparam logic [ADDR_W-1:0] OFF_ALO  = ADDR_W'(16'h0050);
  localparam logic [ADDR_W-1:0] OFF_AHI  = ADDR_W'(16'h0054);
  localparam logic [ADDR_W-1:0] OFF_EN   = ADDR_W'(16'h00fc);
  localparam logic [ADDR_W-1:0] OFF_TB   = ADDR_W'(16'h100c);
  localparam int TTB_BASE = 'h200;

  logic              st_flag, st_write;
  logic [SID_W-1:0]  st_sid;
  logic [CODE_W-1:0] st_code;
  logic [63:0]       cap_addr;
  logic [31:0]       cap_idx, idx_word, status_word;
  logic [NSTREAM-1:0] en_map;
  logic [31:0]       ttb [NSTREAM];

  wire wr_hit  = bus_sel && bus_wr;
  wire clr_req = wr_hit && bus_addr == OFF_STAT && bus_wdata[31];
  wire take    = flt_valid && (!st_flag || clr_req);
  wire benign  = (eng_status | 8'h80) == 8'ha0;

  always_comb begin
    idx_word = '0;
    idx_word[L3_W-1:0] = flt_l3;
    idx_word[L2_LSB +: L2_W] = flt_l2;
    idx_word[TTI_LSB +: TTI_W] = flt_tti;
    status_word = '0;
    status_word[31] = st_flag;
    status_word[30] = st_write;
    status_word[SID_LSB +: SID_W] = st_sid;
    status_word[CODE_W-1:0] = st_code;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_flag <= 1'b0; st_write <= 1'b0; st_sid <= '0; st_code <= '0;
      fault_irq <= 1'b0; cap_addr <= '0; cap_idx <= '0;
    end else if (take) begin
      st_flag <= 1'b1; st_write <= flt_write; st_sid <= flt_sid; st_code <= flt_code;
      fault_irq <= !benign; cap_addr <= flt_addr; cap_idx <= idx_word;
    end else if (clr_req) begin
      st_flag <= 1'b0; st_write <= 1'b0; st_sid <= '0; st_code <= '0;
      fault_irq <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_map <= '0;
    else if (wr_hit && bus_addr == OFF_EN) en_map <= bus_wdata[NSTREAM-1:0];
  end

  for (genvar i = 0; i < NSTREAM; i++) begin : g_ttb
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ttb[i] <= '0;
      else if (wr_hit && bus_addr == ADDR_W'(TTB_BASE + 4*i)) ttb[i] <= bus_wdata;
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      OFF_STAT: bus_rdata = status_word;
      OFF_IDX:  bus_rdata = cap_idx;
      OFF_ALO:  bus_rdata = cap_addr[31:0];
      OFF_AHI:  bus_rdata = cap_addr[63:32];
      OFF_EN:   bus_rdata[NSTREAM-1:0] = en_map;
      OFF_TB:   bus_rdata[1:0] = {st_flag, tb_busy};
      default: ;
    endcase
    for (int i = 0; i < NSTREAM; i++)
      if (bus_addr == ADDR_W'(TTB_BASE + 4*i)) bus_rdata = ttb[i];
  end

  // R2
  capture_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!st_flag && flt_valid) |=> st_flag);
  // R3
  held_addr_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_flag && !clr_req) |=> ($stable(cap_addr) && $stable(cap_idx) && $stable(fault_irq)));
  // R4
  clear_drops_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_req && !flt_valid) |=> (!st_flag && !fault_irq));
  // R5
  clear_with_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_req && flt_valid) |=> (st_flag && cap_addr == $past(flt_addr)));
  // R6
  benign_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && benign) |=> !fault_irq);
  // R6
  irq_needs_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fault_irq |-> st_flag);
endmodule

// File: tb/fault_capture_regs_test.sv
module fault_capture_regs_test;
  logic clk = 0, rst_n = 0;
  logic flt_valid = 0, flt_write = 0;
  logic [3:0] flt_sid = 0;
  logic [7:0] flt_code = 0, eng_status = 0;
  logic [63:0] flt_addr = 0;
  logic [1:0] flt_tti = 0;
  logic [10:0] flt_l2 = 0, flt_l3 = 0;
  logic tb_busy = 0, bus_sel = 0, bus_wr = 0;
  logic [15:0] bus_addr = 0;
  logic [31:0] bus_wdata = 0, bus_rdata;
  logic fault_irq;
  int errors = 0, checks = 0, cyc = 0;
  bit done = 0;

  logic m_flag = 0, m_irq = 0;
  logic [31:0] m_st = 0, m_idx = 0, m_alo = 0, m_ahi = 0;
  logic [3:0] m_en = 0;
  logic [31:0] m_tb [4] = '{0, 0, 0, 0};

  fault_capture_regs uut (.*);

  always #5 clk = ~clk;

  always @(posedge clk) begin
    logic clr;
    if (rst_n) begin
      clr = bus_sel && bus_wr && bus_addr == 16'h0040 && bus_wdata[31];
      if (flt_valid && (!m_flag || clr)) begin
        m_flag = 1;
        m_st = {1'b1, flt_write, 10'b0, flt_sid, 8'b0, flt_code};
        m_idx = {2'b0, flt_tti, 6'b0, flt_l2, flt_l3};
        m_alo = flt_addr[31:0];
        m_ahi = flt_addr[63:32];
        m_irq = (eng_status[6:0] != 7'h20);
      end else if (clr) begin
        m_flag = 0; m_st = 0; m_irq = 0;
      end
      if (bus_sel && bus_wr) begin
        if (bus_addr == 16'h00fc) m_en = bus_wdata[3:0];
        for (int i = 0; i < 4; i++)
          if (bus_addr == 16'h0200 + 16'(4*i)) m_tb[i] = bus_wdata;
      end
    end
  end

  function automatic logic [31:0] mread(input logic [15:0] a);
    case (a)
      16'h0040: return m_st;
      16'h0044: return m_idx;
      16'h0050: return m_alo;
      16'h0054: return m_ahi;
      16'h00fc: return {28'b0, m_en};
      16'h100c: return {30'b0, m_flag, tb_busy};
      16'h0200: return m_tb[0];
      16'h0204: return m_tb[1];
      16'h0208: return m_tb[2];
      16'h020c: return m_tb[3];
      default:  return 32'h0;
    endcase
  endfunction

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n && !done) check({31'b0, fault_irq}, {31'b0, m_irq}, "R6 irq");

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=%0d expected<=20000 cycles", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic tick(); @(posedge clk); @(negedge clk); endtask

  task automatic rd(input logic [15:0] a, input string tag);
    bus_sel = 1; bus_wr = 0; bus_addr = a; #1;
    check(bus_rdata, mread(a), tag);
    bus_sel = 0;
  endtask

  task automatic rd_all(input string tag);
    foreach (addrs[k]) rd(addrs[k], tag);
  endtask

  logic [15:0] addrs [10] = '{16'h40, 16'h44, 16'h50, 16'h54, 16'hfc,
                              16'h100c, 16'h200, 16'h204, 16'h208, 16'h20c};

  task automatic set_fault(input logic w, input logic [3:0] s, input logic [7:0] c,
                           input logic [63:0] a, input logic [7:0] eng);
    flt_valid = 1; flt_write = w; flt_sid = s; flt_code = c; flt_addr = a;
    flt_tti = a[15:14]; flt_l2 = a[26:16]; flt_l3 = a[37:27]; eng_status = eng;
  endtask

  task automatic fault(input logic w, input logic [3:0] s, input logic [7:0] c,
                       input logic [63:0] a, input logic [7:0] eng);
    set_fault(w, s, c, a, eng); tick(); flt_valid = 0;
  endtask

  task automatic wr(input logic [15:0] a, input logic [31:0] d);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d; tick();
    bus_sel = 0; bus_wr = 0;
  endtask

  task automatic clear_and_fault(input logic w, input logic [3:0] s, input logic [7:0] c,
                                 input logic [63:0] a, input logic [7:0] eng);
    set_fault(w, s, c, a, eng);
    bus_sel = 1; bus_wr = 1; bus_addr = 16'h40; bus_wdata = 32'h8000_0000;
    tick();
    flt_valid = 0; bus_sel = 0; bus_wr = 0;
  endtask

  initial begin
    @(negedge clk); @(negedge clk);
    rd_all("R1 reset");
    check({31'b0, fault_irq}, 32'h0, "R1 irq");
    rst_n = 1; @(negedge clk);
    tb_busy = 1; rd(16'h100c, "R9 busy"); tb_busy = 0; rd(16'h100c, "R9 idle");

    fault(1, 4'h5, 8'h12, 64'h0000_0001_2345_4000, 8'h33);
    rd_all("R2 capture");
    rd(16'h100c, "R9 flag");
    fault(0, 4'h9, 8'h77, 64'hffff_0000_dead_8000, 8'h20);
    rd_all("R3 single-shot");

    wr(16'h50, 32'h1111_1111); wr(16'h54, 32'h2222_2222); wr(16'h44, 32'hffff_ffff);
    wr(16'h100c, 32'hffff_ffff); wr(16'h80, 32'hffff_ffff); wr(16'h42, 32'hffff_ffff);
    rd_all("R10 ignored writes"); rd(16'h80, "R10 unimpl"); rd(16'h42, "R10 misaligned");
    wr(16'h40, 32'h7fff_ffff);
    rd_all("R4 bit31 zero no effect");

    wr(16'h40, 32'h8000_0000);
    rd_all("R4 clear");
    fault(0, 4'h3, 8'h04, 64'h0000_0000_dfff_c000, 8'ha0);
    rd_all("R6 benign a0");
    wr(16'h40, 32'h8000_0000);
    fault(1, 4'hf, 8'hff, 64'h8000_0000_0000_4000, 8'h20);
    rd_all("R6 benign 20");
    wr(16'h40, 32'h8000_0000);
    fault(1, 4'h1, 8'h02, 64'h0000_0000_0001_0000, 8'h21);
    rd_all("R6 real 21");
    wr(16'h40, 32'h8000_0000);
    fault(0, 4'h2, 8'h03, 64'h0000_0000_0002_0000, 8'h60);
    rd_all("R6 real 60");

    clear_and_fault(1, 4'ha, 8'h5a, 64'h0123_4567_89ab_c000, 8'ha0);
    rd_all("R5 clear with benign fault");
    clear_and_fault(0, 4'h6, 8'hc3, 64'h0000_00ff_0000_4000, 8'h00);
    rd_all("R5 clear with real fault");
    wr(16'h40, 32'h8000_0000);
    rd_all("R4 clear after R5");

    wr(16'hfc, 32'hffff_ffff); rd(16'hfc, "R7 enable all");
    wr(16'hfc, 32'h0000_000a); rd(16'hfc, "R7 enable pattern");
    for (int i = 0; i < 4; i++) wr(16'h200 + 16'(4*i), 32'h9002_2320 + 32'(i));
    rd_all("R8 table bases");
    wr(16'h210, 32'h1234_5678); rd(16'h210, "R10 beyond array");
    rd_all("R10 array intact");
    tick(); tick();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule